// File: doc/BRIEF.md
# Multiplexed-Address DRAM Strobe Controller

This block connects a simple synchronous requester to a DRAM device driven by row and column strobes over one shared address port. Each request address is split into a row half and a column half. The row half goes out with the row strobe. After a programmable delay, the column half goes out with the column strobe.

Three access modes are offered:
- A single access opens a row, performs one column cycle and closes the row.
- A burst takes one starting column and produces the following columns with an internal counter.
- A page transaction keeps the row open while the requester supplies further arbitrary columns through the same handshake.

Every row access ends with a write-back hold before the row strobe rises. A precharge gap separates consecutive row cycles. A built-in refresh scheduler issues row-only refresh cycles on a rotating row counter. Refresh competes with requester traffic and wins at the next transaction boundary.

Top module: `drc_top`

## Requirements
- R1: The request address is `{row, column}`, with the row in the upper ROW_W bits and the column in the lower COL_W bits. `dram_addr_o` carries the row when `dram_ras_no` falls and the column when `dram_cas_no` falls.
- R2: `dram_ras_no` stays low for exactly T_RCD cycles before the first column strobe falls. Each column strobe stays low for exactly T_CAS cycles, and the column strobe is only low while the row strobe is low.
- R3: A single read produces one `rdata_o` word with `rvalid_o` high for one cycle. That cycle is the first cycle after the column strobe rises.
- R4: A burst (`req_mode_i` = 1) issues BURST_LEN column pulses on columns c, c+1, … modulo 2^COL_W. All of them are reads regardless of `req_we_i`, and the data returns in column order.
- R5: A page transaction (`req_mode_i` = 2) keeps the row strobe low. `req_ready_o` rises between column pulses. Each later accepted request supplies only its column, and its row bits are ignored. The transaction ends on the beat with `req_last_i` = 1.
- R6: A single or page beat with `req_we_i` = 1 stores `req_wdata_i` at the addressed location. `dram_we_no` is low during that column pulse.
- R7: After the last column pulse of an access, the row strobe stays low for exactly T_WB cycles before rising.
- R8: The row strobe stays high for at least T_RP cycles between two low periods.
- R9: A refresh becomes pending every REF_INTERVAL cycles and stays pending until served. A refresh cycle holds the row strobe low for T_RCD+T_WB cycles with no column pulse, on a row counter that starts at 0 and increments modulo 2^ROW_W.
- R10: A pending refresh is started before any new request at the next idle point, and never inside a burst or page transaction. A continuously busy requester therefore cannot hold off refresh.
- R11: After reset, the row, column and write strobes are high, `rvalid_o` is low and `req_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_mode_i | input | 2 | 0 single, 1 burst, 2 page (3 acts as single) |
| req_we_i | input | 1 | Write request |
| req_last_i | input | 1 | Final beat of a page transaction |
| req_addr_i | input | ROW_W+COL_W | `{row, column}` address |
| req_wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data |
| rvalid_o | output | 1 | Read data valid pulse |
| dram_addr_o | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_ras_no | output | 1 | Row strobe, active low |
| dram_cas_no | output | 1 | Column strobe, active low |
| dram_we_no | output | 1 | Write enable, active low |
| dram_dq_o | output | DW | Data to device |
| dram_dq_i | input | DW | Data from device |

## Verification
Timing is measured on the strobe pins at each falling clock edge:
- The bench counts T_RCD cycles from the row strobe falling to the first column strobe.
- Each column strobe is timed at T_CAS cycles.
- The row strobe must rise T_WB cycles after the last column strobe.
- The row strobe must stay high for at least T_RP cycles before the next row cycle.

Read data is due one cycle after the column strobe rises. The monitor checks at that exact sample that the column strobe was low one sample earlier, then pops the scoreboard.

Refresh cycles are recognised as row periods without a column pulse. Each must last T_RCD+T_WB cycles and carry the next expected refresh row. During a long saturating request stream, the number of refreshes is compared with the elapsed cycles divided by REF_INTERVAL.

// File: rtl/drc_pkg.sv
package drc_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_BURST  = 2'd1,
    MODE_PAGE   = 2'd2
  } mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RCD,
    ST_CAS,
    ST_CGAP,
    ST_PWAIT,
    ST_WB,
    ST_REF,
    ST_PRE
  } state_e;
endpackage

// File: rtl/drc_wait_ctr.sv
module drc_wait_ctr #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/drc_refresh_sched.sv
module drc_refresh_sched #(
  parameter int ROW_W    = 4,
  parameter int INTERVAL = 150
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             done_i,
  output logic             pend_o,
  output logic [ROW_W-1:0] row_o
);
  localparam int TW = $clog2(INTERVAL + 1);

  logic [TW-1:0] tmr_q;
  logic          expire;

  assign expire = (tmr_q == TW'(INTERVAL - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q  <= '0;
      pend_o <= 1'b0;
      row_o  <= '0;
    end else begin
      tmr_q <= expire ? '0 : tmr_q + 1'b1;
      // expiry wins over completion so no interval is lost
      if (expire)      pend_o <= 1'b1;
      else if (done_i) pend_o <= 1'b0;
      if (done_i)      row_o <= row_o + 1'b1;
    end
  end

  assert_pend_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o && !done_i) |=> pend_o);

  assert_row_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> (row_o == $past(row_o) + 1'b1));
endmodule

// File: rtl/drc_top.sv
module drc_top #(
  parameter int ROW_W        = 4,
  parameter int COL_W        = 4,
  parameter int DW           = 8,
  parameter int BURST_LEN    = 4,
  parameter int T_RCD        = 3,
  parameter int T_CAS        = 2,
  parameter int T_WB         = 2,
  parameter int T_RP         = 2,
  parameter int REF_INTERVAL = 150,
  localparam int AW  = ROW_W + COL_W,
  localparam int MAW = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_valid_i,
  output logic           req_ready_o,
  input  logic [1:0]     req_mode_i,
  input  logic           req_we_i,
  input  logic           req_last_i,
  input  logic [AW-1:0]  req_addr_i,
  input  logic [DW-1:0]  req_wdata_i,
  output logic [DW-1:0]  rdata_o,
  output logic           rvalid_o,
  output logic [MAW-1:0] dram_addr_o,
  output logic           dram_ras_no,
  output logic           dram_cas_no,
  output logic           dram_we_no,
  output logic [DW-1:0]  dram_dq_o,
  input  logic [DW-1:0]  dram_dq_i
);
  import drc_pkg::*;

  localparam int TSUM = T_RCD + T_CAS + T_WB + T_RP;
  localparam int WCW  = $clog2(TSUM + 1);
  localparam int BW   = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
  localparam int HW   = $clog2(T_RP + 2);

  state_e           state_q, state_d;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  mode_e            mode_q;
  logic             we_q, last_q;
  logic [DW-1:0]    wdata_q;
  logic [BW-1:0]    beats_q;
  logic             ld;
  logic [WCW-1:0]   ldv;
  logic             zero;
  logic             accept;
  logic             ref_pend, ref_done;
  logic [ROW_W-1:0] ref_row;
  logic             burst_more;

  drc_wait_ctr #(.W(WCW)) u_wait (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (ld),
    .val_i  (ldv),
    .zero_o (zero)
  );

  drc_refresh_sched #(.ROW_W(ROW_W), .INTERVAL(REF_INTERVAL)) u_ref (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .done_i (ref_done),
    .pend_o (ref_pend),
    .row_o  (ref_row)
  );

  assign burst_more  = (mode_q == MODE_BURST) && (beats_q != '0);
  assign ref_done    = (state_q == ST_REF) && zero;
  assign req_ready_o = ((state_q == ST_IDLE) && !ref_pend) || (state_q == ST_PWAIT);
  assign accept      = req_ready_o && req_valid_i;

  always_comb begin
    state_d = state_q;
    ld      = 1'b0;
    ldv     = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (ref_pend) begin
          state_d = ST_REF;
          ld      = 1'b1;
          ldv     = WCW'(T_RCD + T_WB - 1);
        end else if (req_valid_i) begin
          state_d = ST_RCD;
          ld      = 1'b1;
          ldv     = WCW'(T_RCD - 1);
        end
      end
      ST_RCD: if (zero) begin
        state_d = ST_CAS;
        ld      = 1'b1;
        ldv     = WCW'(T_CAS - 1);
      end
      ST_CAS: if (zero) begin
        if (burst_more) begin
          state_d = ST_CGAP;
        end else if (mode_q == MODE_PAGE && !last_q) begin
          state_d = ST_PWAIT;
        end else begin
          state_d = ST_WB;
          ld      = 1'b1;
          ldv     = WCW'(T_WB - 1);
        end
      end
      ST_CGAP: begin
        state_d = ST_CAS;
        ld      = 1'b1;
        ldv     = WCW'(T_CAS - 1);
      end
      ST_PWAIT: if (req_valid_i) begin
        state_d = ST_CAS;
        ld      = 1'b1;
        ldv     = WCW'(T_CAS - 1);
      end
      ST_WB, ST_REF: if (zero) begin
        state_d = ST_PRE;
        ld      = 1'b1;
        ldv     = WCW'(T_RP - 1);
      end
      ST_PRE: if (zero) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      row_q    <= '0;
      col_q    <= '0;
      mode_q   <= MODE_SINGLE;
      we_q     <= 1'b0;
      last_q   <= 1'b1;
      wdata_q  <= '0;
      beats_q  <= '0;
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      state_q  <= state_d;
      rvalid_o <= (state_q == ST_CAS) && zero && !we_q;
      if ((state_q == ST_CAS) && zero && !we_q) rdata_o <= dram_dq_i;

      if (state_q == ST_IDLE && ref_pend) begin
        row_q <= ref_row;
      end else if (accept && state_q == ST_IDLE) begin
        row_q   <= req_addr_i[AW-1:COL_W];
        col_q   <= req_addr_i[COL_W-1:0];
        mode_q  <= (req_mode_i == 2'd3) ? MODE_SINGLE : mode_e'(req_mode_i);
        // burst is read-only; the write flag is dropped
        we_q    <= req_we_i && (req_mode_i != MODE_BURST);
        last_q  <= req_last_i;
        wdata_q <= req_wdata_i;
        beats_q <= BW'(BURST_LEN - 1);
      end else if (accept) begin
        col_q   <= req_addr_i[COL_W-1:0];
        we_q    <= req_we_i;
        last_q  <= req_last_i;
        wdata_q <= req_wdata_i;
      end else if (state_q == ST_CAS && zero && burst_more) begin
        col_q   <= col_q + 1'b1;
        beats_q <= beats_q - 1'b1;
      end
    end
  end

  always_comb begin
    dram_addr_o = '0;
    if (state_q inside {ST_CAS, ST_CGAP, ST_PWAIT}) dram_addr_o[COL_W-1:0] = col_q;
    else                                             dram_addr_o[ROW_W-1:0] = row_q;
  end

  assign dram_ras_no = !(state_q inside {ST_RCD, ST_CAS, ST_CGAP, ST_PWAIT, ST_WB, ST_REF});
  assign dram_cas_no = !(state_q == ST_CAS);
  assign dram_we_no  = !((state_q == ST_CAS) && we_q);
  assign dram_dq_o   = wdata_q;

  // cycles the row strobe has been high, saturating
  logic [HW-1:0] hi_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        hi_cnt_q <= HW'(T_RP + 1);
    else if (!dram_ras_no)              hi_cnt_q <= '0;
    else if (hi_cnt_q != HW'(T_RP + 1)) hi_cnt_q <= hi_cnt_q + 1'b1;
  end

  assert_precharge_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dram_ras_no) |-> (hi_cnt_q >= HW'(T_RP)));

  assert_cas_in_row_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dram_cas_no |-> !dram_ras_no);

  assert_refresh_first_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(dram_ras_no) && $past(ref_pend)) |-> (state_q == ST_REF));

  assert_burst_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CGAP) |-> (col_q == $past(col_q) + 1'b1));
endmodule

// File: tb/sim_drc_top.sv
module sim_drc_top;
  localparam int ROW_W = 4, COL_W = 4, DW = 8, BURST_LEN = 4;
  localparam int T_RCD = 3, T_CAS = 2, T_WB = 2, T_RP = 2, REF_INTERVAL = 150;
  localparam int AW = ROW_W + COL_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0, req_last = 1'b0;
  logic [1:0] req_mode = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rvalid, ras_n, cas_n, we_n;
  logic [DW-1:0] rdata, dq_o, dq_i;
  logic [3:0] dram_addr;

  always #5 clk = ~clk;

  drc_top #(.ROW_W(ROW_W), .COL_W(COL_W), .DW(DW), .BURST_LEN(BURST_LEN),
            .T_RCD(T_RCD), .T_CAS(T_CAS), .T_WB(T_WB), .T_RP(T_RP),
            .REF_INTERVAL(REF_INTERVAL)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_mode_i(req_mode), .req_we_i(req_we), .req_last_i(req_last),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .rdata_o(rdata), .rvalid_o(rvalid),
    .dram_addr_o(dram_addr), .dram_ras_no(ras_n), .dram_cas_no(cas_n),
    .dram_we_no(we_n), .dram_dq_o(dq_o), .dram_dq_i(dq_i));

  int compared = 0, mismatched = 0;
  logic [DW-1:0] mem [256];
  logic [DW-1:0] shadow [256];
  logic [DW-1:0] expq [$];
  logic [3:0] rowq [$];
  logic [3:0] row_lat = '0, exp_ref_row = '0, cur_row = '0;
  int ref_count = 0;

  assign dq_i = mem[{row_lat, dram_addr}];

  task automatic check(input bit ok, input string r, input string what, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
    end
  endtask

  // device model and strobe-timing monitor
  bit prev_ras = 1, prev_cas = 1, saw_cas = 0;
  int pre_cnt = 0, cas_cnt = 0, wb_cnt = 0, low_cnt = 0, hi_cnt = 100;
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_ras = 1; prev_cas = 1;
    end else begin
      if (rvalid) begin
        check(prev_cas == 0 && cas_n == 1, "R3", "rvalid not one cycle after column strobe", int'(prev_cas), 0);
        if (expq.size() == 0) check(0, "R3", "unexpected read data", int'(rdata), -1);
        else begin
          logic [DW-1:0] e;
          e = expq.pop_front();
          check(rdata == e, "R4/R5", "read data", int'(rdata), int'(e));
        end
      end
      if (cas_n && !prev_cas) begin
        check(cas_cnt == T_CAS, "R2", "column strobe width", cas_cnt, T_CAS);
        wb_cnt = 0;
      end
      if (!ras_n) begin
        if (prev_ras) begin
          check(hi_cnt >= T_RP, "R8", "precharge gap", hi_cnt, T_RP);
          row_lat = dram_addr; pre_cnt = 0; saw_cas = 0; low_cnt = 0; wb_cnt = 0;
        end
        low_cnt++;
        if (!cas_n) begin
          if (prev_cas) begin
            if (!saw_cas) begin
              logic [3:0] er;
              check(pre_cnt == T_RCD, "R2", "row-to-column delay", pre_cnt, T_RCD);
              er = (rowq.size() != 0) ? rowq.pop_front() : 4'hx;
              check(row_lat === er, "R1", "row on address at row strobe", int'(row_lat), int'(er));
            end
            saw_cas = 1; cas_cnt = 0;
            if (!we_n) mem[{row_lat, dram_addr}] = dq_o;
          end
          cas_cnt++;
        end else begin
          if (!saw_cas) pre_cnt++;
          else wb_cnt++;
        end
      end else begin
        if (!prev_ras) begin
          if (saw_cas) check(wb_cnt == T_WB, "R7", "write-back hold", wb_cnt, T_WB);
          else begin
            check(low_cnt == T_RCD + T_WB, "R9", "refresh row strobe length", low_cnt, T_RCD + T_WB);
            check(row_lat == exp_ref_row, "R9", "refresh row", int'(row_lat), int'(exp_ref_row));
            exp_ref_row++;
            ref_count++;
          end
          hi_cnt = 0;
        end
        hi_cnt++;
      end
      prev_ras = ras_n; prev_cas = cas_n;
    end
  end

  // driver: pushes expectations, then performs the handshake
  task automatic send(input logic [1:0] m, input bit we, input logic [7:0] a,
                      input logic [7:0] wd, input bit last, input bit first);
    if (first) begin
      cur_row = a[7:4];
      rowq.push_back(a[7:4]);
    end
    if (m == 2'd1) begin
      for (int i = 0; i < BURST_LEN; i++) begin
        logic [3:0] c;
        c = a[3:0] + 4'(i);
        expq.push_back(shadow[{cur_row, c}]);
      end
    end else if (we) shadow[{cur_row, a[3:0]}] = wd;
    else expq.push_back(shadow[{cur_row, a[3:0]}]);
    req_mode = m; req_we = we; req_addr = a; req_wdata = wd; req_last = last;
    req_valid = 1'b1;
    forever begin
      if (req_ready) begin
        @(posedge clk);
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    repeat (40) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "ALL", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i) ^ 8'h5A;
      shadow[i] = 8'(i) ^ 8'h5A;
    end
    repeat (3) @(negedge clk);
    // R11: reset state
    check(ras_n && cas_n && we_n, "R11", "strobes high in reset", int'({ras_n, cas_n, we_n}), 7);
    check(!rvalid, "R11", "rvalid low in reset", int'(rvalid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R11", "ready after reset", int'(req_ready), 1);

    // R3 single reads, R1 address split
    send(2'd0, 0, 8'h12, 0, 1, 1);
    send(2'd0, 0, 8'hA7, 0, 1, 1);
    // R6 single write then read back
    send(2'd0, 1, 8'h3C, 8'hC3, 1, 1);
    send(2'd0, 0, 8'h3C, 0, 1, 1);
    // R4 burst with column wrap
    send(2'd1, 0, 8'h5E, 0, 1, 1);
    // R4 burst with write flag set: still reads, memory unchanged
    send(2'd1, 1, 8'h3B, 8'hFF, 1, 1);
    // R5/R6 page write to arbitrary columns, later row bits ignored
    send(2'd2, 1, 8'h84, 8'h11, 0, 1);
    send(2'd2, 1, 8'hF9, 8'h22, 0, 0);
    send(2'd2, 1, 8'h01, 8'h33, 1, 0);
    // R5 page read of those columns in another order
    send(2'd2, 0, 8'h89, 0, 0, 1);
    send(2'd2, 0, 8'h71, 0, 0, 0);
    send(2'd2, 0, 8'hE4, 0, 0, 0);
    send(2'd2, 0, 8'h00, 0, 1, 0);
    drain();

    // R10: saturating traffic must not starve refresh
    begin
      int r0, cyc;
      r0 = ref_count; cyc = 0;
      fork
        begin
          for (int k = 0; k < 60; k++) begin
            int md;
            md = k % 3;
            if (md == 2) begin
              send(2'd2, 0, 8'($urandom), 0, 0, 1);
              send(2'd2, k[0], 8'($urandom), 8'(k), 1, 0);
            end else send(2'(md), 0, 8'($urandom), 0, 1, 1);
          end
        end
        forever begin @(posedge clk); cyc++; end
      join_any
      disable fork;
      check(ref_count - r0 >= cyc / REF_INTERVAL - 1, "R10", "refreshes under load",
            ref_count - r0, cyc / REF_INTERVAL - 1);
    end
    drain();
    check(expq.size() == 0, "R3", "outstanding reads", expq.size(), 0);
    check(rowq.size() == 0, "R1", "outstanding row cycles", rowq.size(), 0);
    check(ref_count >= 2, "R9", "refresh count", ref_count, 2);
    finish_run();
  end
endmodule